// File: doc/BRIEF.md
# Buck Regulator Fault Supervisor

This block is the digital supervisor of a synchronous buck converter. It takes digitized versions of the analog signals: two supply comparator flags for VDD, an enable level, a strobe once per switching period, and a feedback sample in millivolts. From these it decides whether the switcher may run, when power-good is asserted, and how the two gate drivers behave after a fault. The nominal feedback level is 600 mV. The thresholds are fixed percentages of that nominal, and all of them are derived from a parameter.

After the supply comes up, the block emits a one-cycle power-on reset pulse and then runs a soft-start counter. Switching is permitted only when that counter has completed, enable is high and no fault is latched. The block latches two faults. An over-voltage fault clamps the low-side driver on. A counted under-voltage fault turns both drivers off. Both faults stay latched until enable goes low or the supply drops out. The modulator, the comparators and the drivers are outside the block.

Top module: `buck_fault_supervisor`

## Requirements
- R1: The internal supply-good state sets on a clock edge where `vdd_above_on` (VDD above 3 V) is high, and clears only on an edge where `vdd_above_off` (VDD above 2.4 V) is low. In between, it holds its value.
- R2: `por_pulse` is high for exactly one cycle, in the cycle in which supply-good has just become true. It restarts the soft-start count from zero.
- R3: The soft-start counter advances one step per clock while supply-good and `en_in` are both high. It returns to zero whenever either of them is low. `sw_run` is high only once the counter has reached SS_CYCLES, with `en_in` high and no fault latched.
- R4: Power-good uses a hysteresis state. That state goes low on an edge where feedback is below 540 mV, goes high on an edge where feedback is above 552 mV, and otherwise holds.
- R5: `pgood` is high only while the hysteresis state is high, feedback is at or below 720 mV, and `sw_run` is high. A low enable or any latched fault therefore forces it low.
- R6: `ov_fault` sets after OV_DELAY consecutive clocks with feedback above 720 mV, while enabled with supply-good. Any sample at or below 720 mV restarts the count.
- R7: While `ov_fault` is set with supply-good, `ls_gate_en` is 1, `hs_gate_en` is 0, `sw_run` is 0 and `pgood` is 0. This holds regardless of the feedback value.
- R8: `uv_fault` sets on the UV_STROBES-th (default 8) consecutive switching strobe with feedback below 450 mV while running. A strobe with feedback at or above 450 mV restarts the count.
- R9: While `uv_fault` is set and `ov_fault` is clear, both `hs_gate_en` and `ls_gate_en` are 0.
- R10: Both faults clear on the first edge where `en_in` is low or supply-good is false. A fresh soft-start follows.
- R11: If both faults are latched, the over-voltage response wins: `ls_gate_en` is 1 and `hs_gate_en` is 0.
- R12: While supply-good is false, both gate enables, `sw_run` and `pgood` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cyc_strobe | input | 1 | One-clock pulse per switching period |
| en_in | input | 1 | Controller enable level |
| vdd_above_on | input | 1 | Comparator flag: VDD above the 3 V turn-on level |
| vdd_above_off | input | 1 | Comparator flag: VDD above the 2.4 V turn-off level |
| fb_mv | input | FB_W | Feedback sample in millivolts |
| pgood | output | 1 | Power-good |
| hs_gate_en | output | 1 | High-side driver enable |
| ls_gate_en | output | 1 | Low-side driver enable |
| sw_run | output | 1 | Switcher permitted to modulate |
| por_pulse | output | 1 | One-cycle power-on reset pulse |
| ov_fault | output | 1 | Latched over-voltage fault |
| uv_fault | output | 1 | Latched under-voltage fault |

## Verification
The assertions assume three things about the inputs: `cyc_strobe` is a single-clock pulse, the two supply flags are consistent (the 3 V flag is never high while the 2.4 V flag is low), and the feedback sample is held steady between clock edges. The stimulus drives every input one time unit after a rising edge. It produces the strobe from a free-running divide-by-four counter and moves the two supply flags together in the order a real supply ramp would. Feedback steps are placed to straddle each threshold and to break each qualification count one sample before it would complete.

// File: rtl/bsup_pkg.sv
package bsup_pkg;

   // Percentage of a nominal value, rounded down.
   function automatic int unsigned pct_of(input int unsigned nom, input int unsigned pct);
      return (nom * pct) / 100;
   endfunction

   // Driver arrangement chosen by the supervisor.
   typedef enum logic [1:0] {
      DRV_OFF      = 2'd0,
      DRV_RUN      = 2'd1,
      DRV_LS_CLAMP = 2'd2
   } drv_mode_e;

endpackage

// File: rtl/bsup_supply.sv
module bsup_supply #(
   parameter int unsigned SS_CYCLES = 512
) (
   input  logic clk,
   input  logic rst_n,
   input  logic vdd_on,
   input  logic vdd_off,
   input  logic en,
   output logic supply_ok,
   output logic por,
   output logic ss_done
);
   localparam int unsigned SS_W = $clog2(SS_CYCLES + 1);
   localparam logic [SS_W-1:0] SS_END = SS_W'(SS_CYCLES);

   logic [SS_W-1:0] ss_cnt;

   generate
      if (SS_CYCLES < 1) begin : g_bad_ss
         $error("SS_CYCLES must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         supply_ok <= 1'b0;
         por       <= 1'b0;
      end else begin
         por <= !supply_ok && vdd_on;
         if (!supply_ok && vdd_on)
            supply_ok <= 1'b1;
         else if (supply_ok && !vdd_off)
            supply_ok <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ss_cnt <= '0;
      else if (!supply_ok || !en)
         ss_cnt <= '0;
      else if (ss_cnt != SS_END)
         ss_cnt <= ss_cnt + 1'b1;
   end

   assign ss_done = (ss_cnt == SS_END);

endmodule

// File: rtl/bsup_consec_filter.sv
module bsup_consec_filter #(
   parameter int unsigned N = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic tick,
   input  logic cond,
   output logic fire
);
   generate
      if (N < 1) begin : g_bad_n
         $error("N must be at least 1");
      end else if (N == 1) begin : g_direct
         assign fire = !clr && tick && cond;
      end else begin : g_count
         localparam int unsigned CW = $clog2(N);
         localparam logic [CW-1:0] LAST = CW'(N - 1);
         logic [CW-1:0] cnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cnt <= '0;
            else if (clr)
               cnt <= '0;
            else if (tick) begin
               if (!cond)
                  cnt <= '0;
               else if (cnt != LAST)
                  cnt <= cnt + 1'b1;
            end
         end

         assign fire = !clr && tick && cond && (cnt == LAST);
      end
   endgenerate

endmodule

// File: rtl/bsup_pgood_hyst.sv
module bsup_pgood_hyst #(
   parameter int unsigned FB_W  = 12,
   parameter int unsigned LO_MV = 540,
   parameter int unsigned HI_MV = 552
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [FB_W-1:0] fb,
   output logic            pg_state
);
   localparam logic [FB_W-1:0] LO_TH = FB_W'(LO_MV);
   localparam logic [FB_W-1:0] HI_TH = FB_W'(HI_MV);

   generate
      if (HI_MV < LO_MV) begin : g_bad_band
         $error("upper power-good level below lower level");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pg_state <= 1'b0;
      else if (fb < LO_TH)
         pg_state <= 1'b0;
      else if (fb > HI_TH)
         pg_state <= 1'b1;
   end

endmodule

// File: rtl/buck_fault_supervisor.sv
module buck_fault_supervisor
   import bsup_pkg::*;
#(
   parameter int unsigned FB_W       = 12,
   parameter int unsigned NOM_MV     = 600,
   parameter int unsigned SS_CYCLES  = 512,
   parameter int unsigned OV_DELAY   = 625,
   parameter int unsigned UV_STROBES = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cyc_strobe,
   input  logic            en_in,
   input  logic            vdd_above_on,
   input  logic            vdd_above_off,
   input  logic [FB_W-1:0] fb_mv,
   output logic            pgood,
   output logic            hs_gate_en,
   output logic            ls_gate_en,
   output logic            sw_run,
   output logic            por_pulse,
   output logic            ov_fault,
   output logic            uv_fault
);
   localparam int unsigned PG_LO_MV = pct_of(NOM_MV, 90);
   localparam int unsigned PG_HI_MV = pct_of(NOM_MV, 92);
   localparam int unsigned OV_MV    = pct_of(NOM_MV, 120);
   localparam int unsigned UV_MV    = pct_of(NOM_MV, 75);
   localparam logic [FB_W-1:0] OV_TH = FB_W'(OV_MV);
   localparam logic [FB_W-1:0] UV_TH = FB_W'(UV_MV);

   generate
      if (OV_MV >= (1 << FB_W)) begin : g_bad_width
         $error("FB_W too narrow for the over-voltage level");
      end
   endgenerate

   logic      supply_ok, ss_done, pg_state;
   logic      ov_hit, uv_hit, fault_clr, fb_over, fb_under;
   logic      ov_q, uv_q;
   drv_mode_e drv_mode;

   bsup_supply #(.SS_CYCLES(SS_CYCLES)) u_supply (
      .clk(clk), .rst_n(rst_n),
      .vdd_on(vdd_above_on), .vdd_off(vdd_above_off), .en(en_in),
      .supply_ok(supply_ok), .por(por_pulse), .ss_done(ss_done)
   );

   bsup_pgood_hyst #(.FB_W(FB_W), .LO_MV(PG_LO_MV), .HI_MV(PG_HI_MV)) u_pg (
      .clk(clk), .rst_n(rst_n), .fb(fb_mv), .pg_state(pg_state)
   );

   assign fb_over   = (fb_mv > OV_TH);
   assign fb_under  = (fb_mv < UV_TH);
   assign fault_clr = !en_in || !supply_ok;

   bsup_consec_filter #(.N(OV_DELAY)) u_ov_filt (
      .clk(clk), .rst_n(rst_n), .clr(fault_clr || ov_q),
      .tick(1'b1), .cond(fb_over), .fire(ov_hit)
   );

   bsup_consec_filter #(.N(UV_STROBES)) u_uv_filt (
      .clk(clk), .rst_n(rst_n), .clr(!sw_run),
      .tick(cyc_strobe), .cond(fb_under), .fire(uv_hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ov_q <= 1'b0;
         uv_q <= 1'b0;
      end else if (fault_clr) begin
         ov_q <= 1'b0;
         uv_q <= 1'b0;
      end else begin
         ov_q <= ov_q || ov_hit;
         uv_q <= uv_q || uv_hit;
      end
   end

   assign sw_run = supply_ok && en_in && ss_done && !ov_q && !uv_q;

   always_comb begin
      if (ov_q && supply_ok)
         drv_mode = DRV_LS_CLAMP;
      else if (sw_run)
         drv_mode = DRV_RUN;
      else
         drv_mode = DRV_OFF;
   end

   assign hs_gate_en = (drv_mode == DRV_RUN);
   assign ls_gate_en = (drv_mode != DRV_OFF);
   assign pgood      = pg_state && !fb_over && sw_run;
   assign ov_fault   = ov_q;
   assign uv_fault   = uv_q;

endmodule

// File: rtl/buck_fault_supervisor_chk.sv
module buck_fault_supervisor_chk #(
   parameter int unsigned FB_W   = 12,
   parameter int unsigned NOM_MV = 600
) (
   input logic            clk,
   input logic            rst_n,
   input logic            strobe,
   input logic            en,
   input logic            sup,
   input logic [FB_W-1:0] fb,
   input logic            pgood,
   input logic            hs,
   input logic            ls,
   input logic            run,
   input logic            por,
   input logic            ovf,
   input logic            uvf
);
   localparam logic [FB_W-1:0] OV_TH = FB_W'((NOM_MV * 120) / 100);
   localparam logic [FB_W-1:0] UV_TH = FB_W'((NOM_MV * 75) / 100);

   a_r2_por_single: assert property (@(posedge clk) disable iff (!rst_n)
      por |=> !por);
   a_r3_run_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> en && sup);
   a_r5_pg_over: assert property (@(posedge clk) disable iff (!rst_n)
      (fb > OV_TH) |-> !pgood);
   a_r6_ov_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf) |-> $past(fb > OV_TH));
   a_r7_ov_clamp: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf && sup) |-> ls && !hs && !pgood);
   a_r8_uv_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(uvf) |-> $past(strobe && fb < UV_TH));
   a_r9_uv_tristate: assert property (@(posedge clk) disable iff (!rst_n)
      (uvf && !ovf) |-> !hs && !ls);
   a_r10_en_clears: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !ovf && !uvf);
   a_r12_uvlo_off: assert property (@(posedge clk) disable iff (!rst_n)
      !sup |-> !hs && !ls && !run && !pgood);

endmodule

bind buck_fault_supervisor buck_fault_supervisor_chk #(.FB_W(FB_W), .NOM_MV(NOM_MV)) u_chk (
   .clk(clk), .rst_n(rst_n), .strobe(cyc_strobe), .en(en_in), .sup(supply_ok),
   .fb(fb_mv), .pgood(pgood), .hs(hs_gate_en), .ls(ls_gate_en), .run(sw_run),
   .por(por_pulse), .ovf(ov_fault), .uvf(uv_fault)
);

// File: tb/buck_fault_supervisor_tb.sv
`timescale 1ns/1ps
module buck_fault_supervisor_tb;
   localparam int FB_W = 12;
   localparam int SS   = 512;
   localparam int OVD  = 625;
   localparam int UVN  = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic strobe = 1'b0;
   logic en = 1'b0;
   logic von = 1'b0;
   logic voff = 1'b0;
   logic [FB_W-1:0] fb = '0;
   logic pgood, hs, ls, run, por, ovf, uvf;

   int total = 0;
   int bad   = 0;
   bit ended = 0;

   always #4 clk = ~clk;

   buck_fault_supervisor #(.FB_W(FB_W), .NOM_MV(600), .SS_CYCLES(SS),
      .OV_DELAY(OVD), .UV_STROBES(UVN)) u_dut (
      .clk(clk), .rst_n(rst_n), .cyc_strobe(strobe), .en_in(en),
      .vdd_above_on(von), .vdd_above_off(voff), .fb_mv(fb),
      .pgood(pgood), .hs_gate_en(hs), .ls_gate_en(ls), .sw_run(run),
      .por_pulse(por), .ov_fault(ovf), .uv_fault(uvf)
   );

   // strobe: one clock in four
   int sdiv = 0;
   always @(posedge clk) begin
      #1;
      sdiv = (sdiv + 1) % 4;
      strobe = (sdiv == 0);
   end

   // behavioural reference model
   int m_sup = 0, m_por = 0, m_ss = 0, m_ov = 0, m_uv = 0, m_ovc = 0, m_uvc = 0, m_pg = 0;

   function automatic int m_run();
      return (m_sup != 0 && en && m_ss == SS && m_ov == 0 && m_uv == 0) ? 1 : 0;
   endfunction

   always @(posedge clk) begin
      int runnow, clr, ovfire, uvfire;
      if (!rst_n) begin
         m_sup = 0; m_por = 0; m_ss = 0; m_ov = 0; m_uv = 0; m_ovc = 0; m_uvc = 0; m_pg = 0;
      end else begin
         runnow = m_run();
         clr = (!en || m_sup == 0) ? 1 : 0;
         ovfire = 0; uvfire = 0;
         if (clr != 0 || m_ov != 0) m_ovc = 0;
         else if (fb > 720) begin
            if (m_ovc == OVD - 1) ovfire = 1; else m_ovc++;
         end else m_ovc = 0;
         if (runnow == 0) m_uvc = 0;
         else if (strobe) begin
            if (fb < 450) begin
               if (m_uvc == UVN - 1) uvfire = 1; else m_uvc++;
            end else m_uvc = 0;
         end
         if (clr != 0) begin m_ov = 0; m_uv = 0; end
         else begin
            if (ovfire != 0) m_ov = 1;
            if (uvfire != 0) m_uv = 1;
         end
         if (m_sup == 0 || !en) m_ss = 0;
         else if (m_ss < SS) m_ss++;
         m_por = (m_sup == 0 && von) ? 1 : 0;
         if (m_sup == 0 && von) m_sup = 1;
         else if (m_sup != 0 && !voff) m_sup = 0;
         if (fb < 540) m_pg = 0;
         else if (fb > 552) m_pg = 1;
      end
   end

   task automatic cmp(input string tag, input logic act, input int exp);
      total++;
      if (act !== (exp != 0)) begin
         bad++;
         $display("FAIL %s actual=%0b expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      int r, lsx, hsx, pgx;
      if (rst_n && !ended) begin
         r   = m_run();
         hsx = (m_ov != 0 && m_sup != 0) ? 0 : r;
         lsx = ((m_ov != 0 && m_sup != 0) || r != 0) ? 1 : 0;
         pgx = (m_pg != 0 && fb <= 720 && r != 0) ? 1 : 0;
         cmp("R3 model sw_run", run, r);
         cmp("R7 model hs_gate_en", hs, hsx);
         cmp("R9 model ls_gate_en", ls, lsx);
         cmp("R5 model pgood", pgood, pgx);
         cmp("R2 model por_pulse", por, m_por);
         cmp("R6 model ov_fault", ovf, m_ov);
         cmp("R8 model uv_fault", uvf, m_uv);
      end
   end

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic chk(input string tag, input logic act, input logic exp);
      @(negedge clk);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      fb = 12'd600;
      step(3);
      rst_n = 1'b1;
      step(1);
      chk("R12 reset run", run, 1'b0);
      chk("R12 reset ls", ls, 1'b0);
      chk("R5 reset pgood", pgood, 1'b0);

      // supply ramp, R2 and R3
      en = 1'b1; voff = 1'b1; von = 1'b1;
      @(posedge clk); #1;
      @(negedge clk);
      total++; if (por !== 1'b1) begin bad++; $display("FAIL R2 por actual=%0b expected=1", por); end
      @(negedge clk);
      total++; if (por !== 1'b0) begin bad++; $display("FAIL R2 por width actual=%0b expected=0", por); end
      repeat (SS - 2) @(negedge clk);
      total++; if (run !== 1'b0) begin bad++; $display("FAIL R3 early run actual=%0b expected=0", run); end
      @(negedge clk);
      total++; if (run !== 1'b1) begin bad++; $display("FAIL R3 run actual=%0b expected=1", run); end
      step(1);
      chk("R5 pgood running", pgood, 1'b1);

      // power-good hysteresis R4
      fb = 12'd545; step(3); chk("R4 inside band holds high", pgood, 1'b1);
      fb = 12'd535; step(3); chk("R4 below 540", pgood, 1'b0);
      fb = 12'd548; step(3); chk("R4 inside band holds low", pgood, 1'b0);
      fb = 12'd560; step(3); chk("R4 above 552", pgood, 1'b1);

      // over-voltage qualification R6
      fb = 12'd730; step(3); chk("R5 pgood over 720", pgood, 1'b0);
      step(OVD - 10);
      fb = 12'd720; step(1);
      chk("R6 restart no fault", ovf, 1'b0);
      fb = 12'd730; step(OVD - 1);
      chk("R6 one short", ovf, 1'b0);
      step(1);
      chk("R6 fault set", ovf, 1'b1);
      fb = 12'd600; step(20);
      chk("R7 ls clamp", ls, 1'b1);
      chk("R7 hs off", hs, 1'b0);
      chk("R7 run off", run, 1'b0);
      chk("R7 pgood low", pgood, 1'b0);

      // clear by enable R10
      en = 1'b0; step(2);
      chk("R10 ov cleared", ovf, 1'b0);
      chk("R10 ls released", ls, 1'b0);
      en = 1'b1; step(SS + 2);
      chk("R10 restart run", run, 1'b1);

      // under-voltage R8/R9
      fb = 12'd440; step(4 * (UVN - 3));
      chk("R8 short run no fault", uvf, 1'b0);
      fb = 12'd450; step(8);
      fb = 12'd440; step(4 * (UVN - 2));
      chk("R8 restarted count", uvf, 1'b0);
      step(4 * 4);
      chk("R8 uv set", uvf, 1'b1);
      chk("R9 hs off", hs, 1'b0);
      chk("R9 ls off", ls, 1'b0);
      chk("R5 pgood under uv", pgood, 1'b0);

      // priority R11
      fb = 12'd730; step(OVD + 4);
      chk("R11 ov also set", ovf, 1'b1);
      chk("R11 uv still set", uvf, 1'b1);
      chk("R11 ls on", ls, 1'b1);
      chk("R11 hs off", hs, 1'b0);

      // supply hysteresis R1, UVLO R12
      fb = 12'd600; en = 1'b0; step(2); en = 1'b1; step(SS + 3);
      von = 1'b0; step(10);
      chk("R1 hold between levels", run, 1'b1);
      voff = 1'b0; step(2);
      chk("R12 run off", run, 1'b0);
      chk("R12 hs off", hs, 1'b0);
      chk("R12 ls off", ls, 1'b0);
      voff = 1'b1; step(6);
      chk("R1 no restart below on level", run, 1'b0);
      chk("R1 no por below on level", por, 1'b0);
      von = 1'b1; step(1);
      chk("R2 por on return", por, 1'b1);
      step(SS + 2);
      chk("R3 run after restart", run, 1'b1);
      step(4);
      finish_run();
   end
endmodule